// File: doc/BRIEF.md
# Upstream Bus Request Controller

This block decides when a bridge asks for ownership of its upstream bus and when it takes that ownership. It watches whether the upstream queues hold work and whether the oldest request has been fully queued. It raises an active-low request line and then waits for the external arbiter's active-low grant. When ownership is won, it sends a one-cycle start strobe to the initiator engine. The engine later reports how the transaction ended, and that report also tells this block the transaction is over.

Three endings (retry, disconnect and target abort) make the block withdraw its request for a fixed two-clock back-off. A normal completion leaves the request in place when more work is queued. If the arbiter grants the bus while the block is not requesting and no transaction is running, the block enables its bus-parking drivers. When work arrives while the bus is parked, the block starts at once, with no separate request phase.

All pins are plain control signals: no data passes through this block, so there is no valid/ready interface and no back-pressure. Every output comes from a register, is clocked by `clk`, and is cleared by the active-low asynchronous reset.

Top module: `upbus_req_ctrl`

## Requirements
- R1: While `rst_n` is low, `req_n` is 1, `start` is 0 and `park_en` is 0, whatever the other inputs are.
- R2: `req_n` goes low on the clock after an edge where `work_pending` and `req_queued` are both 1, provided no back-off is active.
- R3: `req_n` stays low on every following clock while `work_pending` and `req_queued` stay 1 and no back-off ending is reported.
- R4: While `req_queued` is 0, `req_n` stays 1 even when `work_pending` is 1.
- R5: Take a `term_valid` pulse with `term_code` equal to 1 (retry), 2 (disconnect) or 3 (target abort). `req_n` is 1 for exactly two clocks after the edge that samples it. It returns low on the third clock if work is still pending.
- R6: A second back-off ending that arrives while a back-off is running restarts the two-clock count from that edge.
- R7: `term_valid` with `term_code` 0 (normal completion) causes no back-off. `req_n` stays low when work is still pending.
- R8: When an edge samples `req_n` low and `gnt_n` low, with no transaction running, `start` is 1 for the clock after that edge.
- R9: `start` is a single-clock pulse. No further pulse is issued until `term_valid` has ended the running transaction, even if `gnt_n` stays low.
- R10: When an edge samples `gnt_n` low, `req_n` high and no transaction running, `park_en` is 1 on the next clock.
- R11: `park_en` is 0 on the first clock after an edge that samples `gnt_n` high.
- R12: When the bus is parked and pending work is sampled with `gnt_n` still low, `start` pulses on the next clock, the same clock in which `req_n` first goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| work_pending | input | 1 | Upstream queues hold a posted write or a delayed request |
| req_queued | input | 1 | The pending request has been completely queued |
| gnt_n | input | 1 | Bus grant from the arbiter, active low |
| term_valid | input | 1 | The initiator engine reports the end of the running transaction |
| term_code | input | 2 | How it ended: 0 normal, 1 retry, 2 disconnect, 3 target abort |
| req_n | output | 1 | Bus request to the arbiter, active low |
| start | output | 1 | One-clock strobe telling the initiator engine to begin |
| park_en | output | 1 | Drive address/data, command/byte-enable and parity to valid levels |

## Verification
The assertions assume the following about the inputs:
- `term_valid` is pulsed only by the initiator engine and is never held across a new start.
- `term_code` is meaningful only while `term_valid` is high.
- All inputs are settled before each rising edge.

The stimulus changes every input on the falling edge and pulses `term_valid` for one clock, except where two endings in a row are reported on purpose to show the back-off restarting. The grant is lowered only in the situations the arbiter would create: after a request, or while the block is idle, to show parking.

// File: rtl/urc_pkg.sv
package urc_pkg;
  typedef enum logic [1:0] {
    END_NORMAL = 2'd0,
    END_RETRY  = 2'd1,
    END_DISC   = 2'd2,
    END_ABORT  = 2'd3
  } end_code_e;

  function automatic logic is_backoff_end(input logic [1:0] code);
    return code != END_NORMAL;
  endfunction
endpackage

// File: rtl/urc_backoff.sv
module urc_backoff #(
  parameter int BACKOFF_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       term_valid,
  input  logic [1:0] term_code,
  output logic       hold
);
  import urc_pkg::*;
  localparam int CNT_W = $clog2(BACKOFF_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             bad_end;

  assign bad_end = term_valid && is_backoff_end(term_code);

  always_comb begin
    if (bad_end)
      cnt_d = CNT_W'(BACKOFF_CYCLES);
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
    else
      cnt_d = cnt_q;
  end

  assign hold = (cnt_d != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R6
  restart_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_end |=> (cnt_q == CNT_W'(BACKOFF_CYCLES)));
endmodule

// File: rtl/urc_req_park.sv
module urc_req_park (
  input  logic clk,
  input  logic rst_n,
  input  logic pend,
  input  logic hold,
  input  logic gnt_low,
  input  logic busy,
  output logic req_q,
  output logic park_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      park_q <= 1'b0;
    end else begin
      req_q  <= pend && !hold;
      park_q <= gnt_low && !req_q && !busy;
    end
  end

  // R10
  park_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_low && !req_q && !busy) |=> park_q);
  // R11
  park_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_low |=> !park_q);
  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && pend && !hold) |=> req_q);
endmodule

// File: rtl/urc_start.sv
module urc_start (
  input  logic clk,
  input  logic rst_n,
  input  logic pend,
  input  logic hold,
  input  logic gnt_low,
  input  logic req_q,
  input  logic park_q,
  input  logic term_valid,
  output logic busy_q,
  output logic start_q
);
  logic go;

  assign go = !busy_q && gnt_low && (req_q || park_q) && pend && !hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= go;
      if (go)              busy_q <= 1'b1;
      else if (term_valid) busy_q <= 1'b0;
    end
  end

  // R8
  start_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && gnt_low && !busy_q && pend && !hold) |=> start_q);
  // R9
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);
  // R9
  no_restart_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !term_valid) |=> !start_q);
endmodule

// File: rtl/upbus_req_ctrl.sv
module upbus_req_ctrl #(
  parameter int BACKOFF_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       work_pending,
  input  logic       req_queued,
  input  logic       gnt_n,
  input  logic       term_valid,
  input  logic [1:0] term_code,
  output logic       req_n,
  output logic       start,
  output logic       park_en
);
  import urc_pkg::*;

  logic pend, hold, gnt_low, req_q, park_q, busy_q, start_q;

  assign pend    = work_pending && req_queued;
  assign gnt_low = !gnt_n;

  urc_backoff #(.BACKOFF_CYCLES(BACKOFF_CYCLES)) u_backoff (
    .clk(clk), .rst_n(rst_n), .term_valid(term_valid),
    .term_code(term_code), .hold(hold)
  );

  urc_req_park u_req_park (
    .clk(clk), .rst_n(rst_n), .pend(pend), .hold(hold),
    .gnt_low(gnt_low), .busy(busy_q), .req_q(req_q), .park_q(park_q)
  );

  urc_start u_start (
    .clk(clk), .rst_n(rst_n), .pend(pend), .hold(hold),
    .gnt_low(gnt_low), .req_q(req_q), .park_q(park_q),
    .term_valid(term_valid), .busy_q(busy_q), .start_q(start_q)
  );

  assign req_n   = !req_q;
  assign start   = start_q;
  assign park_en = park_q;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (req_n && !start && !park_en));
  // R2 R4
  req_needs_queued_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_n |-> $past(work_pending && req_queued));
  // R5
  backoff_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(term_valid && is_backoff_end(term_code)) |-> req_n);
  // R5 (window of two clocks, default back-off length)
  backoff_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(term_valid && is_backoff_end(term_code), 2) |-> req_n);
  // R7
  normal_keeps_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_n && term_valid && term_code == END_NORMAL && work_pending && req_queued) |=> !req_n);
  // R12
  parked_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (park_en && !gnt_n && work_pending && req_queued && !hold && !busy_q) |=> start);
endmodule

// File: tb/upbus_req_ctrl_tb.sv
module upbus_req_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n, work_pending, req_queued, gnt_n, term_valid;
  logic [1:0] term_code;
  logic req_n, start, park_en;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    int    at;
    int    sig;
    logic  val;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  upbus_req_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .work_pending(work_pending),
    .req_queued(req_queued), .gnt_n(gnt_n), .term_valid(term_valid),
    .term_code(term_code), .req_n(req_n), .start(start), .park_en(park_en)
  );

  function automatic logic sig_val(input int s);
    case (s)
      0:       return req_n;
      1:       return start;
      default: return park_en;
    endcase
  endfunction

  function automatic string sig_name(input int s);
    case (s)
      0:       return "req_n";
      1:       return "start";
      default: return "park_en";
    endcase
  endfunction

  task automatic check(input string tag, input string nm, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at cycle %0d", tag, nm, act, expv, cyc);
    end
  endtask

  // driver side: push an expected value d clocks ahead, kept in time order
  task automatic expect_at(input int d, input int s, input logic v, input string tag);
    exp_t it;
    int pos;
    it.at = cyc + d; it.sig = s; it.val = v; it.tag = tag;
    pos = sb.size();
    for (int i = 0; i < sb.size(); i++) begin
      if (sb[i].at > it.at) begin pos = i; break; end
    end
    sb.insert(pos, it);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // monitor side
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      exp_t it;
      it = sb.pop_front();
      if (it.at < cyc) begin
        checks++; errors++;
        $display("FAIL %s %s stale expectation actual=x expected=%b", it.tag, sig_name(it.sig), it.val);
      end else begin
        check(it.tag, sig_name(it.sig), sig_val(it.sig), it.val);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; work_pending = 1'b1; req_queued = 1'b1;
    gnt_n = 1'b0; term_valid = 1'b0; term_code = 2'd0;
    repeat (3) tick();
    // R1: outputs quiet in reset even with grant low and work pending
    check("R1", "req_n", req_n, 1'b1);
    check("R1", "start", start, 1'b0);
    check("R1", "park_en", park_en, 1'b0);
    gnt_n = 1'b1; work_pending = 1'b0; req_queued = 1'b0;
    rst_n = 1'b1;
    tick();

    // R4: pending but not fully queued
    work_pending = 1'b1;
    for (int k = 1; k <= 3; k++) expect_at(k, 0, 1'b1, "R4");
    repeat (3) tick();

    // R2 / R3: fully queued, request raised and held
    req_queued = 1'b1;
    expect_at(1, 0, 1'b0, "R2");
    expect_at(1, 1, 1'b0, "R2");
    expect_at(2, 0, 1'b0, "R3");
    expect_at(3, 0, 1'b0, "R3");
    repeat (3) tick();

    // R8 / R9: grant while requesting
    gnt_n = 1'b0;
    expect_at(1, 1, 1'b1, "R8");
    expect_at(2, 1, 1'b0, "R9");
    expect_at(3, 1, 1'b0, "R9");
    expect_at(2, 2, 1'b0, "R10");
    repeat (3) tick();

    // R5: retry ending, two-clock back-off
    gnt_n = 1'b1; term_valid = 1'b1; term_code = 2'd1;
    expect_at(1, 0, 1'b1, "R5");
    expect_at(2, 0, 1'b1, "R5");
    expect_at(3, 0, 1'b0, "R5");
    expect_at(1, 1, 1'b0, "R5");
    tick();
    term_valid = 1'b0; term_code = 2'd0;
    repeat (2) tick();

    // R6: disconnect then abort on back-to-back clocks restarts the count
    term_valid = 1'b1; term_code = 2'd2;
    for (int k = 1; k <= 3; k++) expect_at(k, 0, 1'b1, "R6");
    expect_at(4, 0, 1'b0, "R6");
    tick();
    term_code = 2'd3;
    tick();
    term_valid = 1'b0; term_code = 2'd0;
    repeat (2) tick();

    // R7: normal completion keeps request
    gnt_n = 1'b0;
    expect_at(1, 1, 1'b1, "R8");
    tick();
    gnt_n = 1'b1;
    tick();
    term_valid = 1'b1; term_code = 2'd0;
    expect_at(1, 0, 1'b0, "R7");
    expect_at(2, 0, 1'b0, "R7");
    expect_at(1, 1, 1'b0, "R7");
    tick();
    term_valid = 1'b0;
    tick();

    // R10: grant while idle parks the bus
    work_pending = 1'b0;
    expect_at(1, 0, 1'b1, "R10");
    tick();
    gnt_n = 1'b0;
    expect_at(1, 2, 1'b1, "R10");
    expect_at(1, 1, 1'b0, "R10");
    expect_at(2, 2, 1'b1, "R10");
    repeat (2) tick();

    // R12: parked, work arrives, start with no request phase
    work_pending = 1'b1;
    expect_at(1, 1, 1'b1, "R12");
    expect_at(1, 0, 1'b0, "R12");
    expect_at(2, 1, 1'b0, "R12");
    repeat (2) tick();

    term_valid = 1'b1; term_code = 2'd0; work_pending = 1'b0;
    tick();
    term_valid = 1'b0;
    expect_at(1, 2, 1'b1, "R10");
    tick();

    // R11: grant removed, parking dropped next clock
    gnt_n = 1'b1;
    expect_at(1, 2, 1'b0, "R11");
    expect_at(2, 2, 1'b0, "R11");
    repeat (2) tick();

    while (sb.size() > 0) tick();
    tick();
    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule